// File: doc/BRIEF.md
# IRQ/FIQ Steering Interrupt Controller

This controller gathers 32 level-sensitive request lines from peripherals and produces the processor's two interrupt inputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Software enables each line with an enable register. A routing register then sends every enabled line to one of the two outputs. Two read-only views show, per output, which lines are asserting it at the moment. Software uses these views to find the peripheral that raised the request. In a typical system, line 24 serves the serial port, line 25 the display controller, and lines 26 to 29 the four timer channels.

The register block sits in a 32-byte window at `BASE_ADDR`, which defaults to 0x9005_0000. Software reaches it over a simple single-cycle select/write bus, and read data is returned one cycle later. Each output is the OR of its pending view, captured in a flop. Requests are not latched. A peripheral holds its line until its own status is cleared.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset the enable register and the routing register read 0, `irq_o` and `fiq_o` are 0, and `rdata_o` is 0.
- R2: A write to offset 0x04 loads the enable register, and a write to offset 0x08 loads the routing register. Each reads back the value written.
- R3: A read at offset 0x0C returns the normal pending view, `src_i & enable & ~routing`. A line whose enable bit is 0 never appears in it.
- R4: A read at offset 0x10 returns the fast pending view, `src_i & enable & routing`. A routing bit of 1 selects the fast output.
- R5: `irq_o` equals the OR of the normal pending view as it stood before the previous rising clock edge.
- R6: `fiq_o` equals the OR of the fast pending view as it stood before the previous rising clock edge.
- R7: A read at offset 0x00 returns the raw `src_i` lines.
- R8: Writes to offsets 0x00, 0x0C, 0x10 and to unmapped offsets (0x14 to 0x1C) change no state. Reads of unmapped offsets return 0.
- R9: An access whose address bits [31:5] differ from those of `BASE_ADDR` is ignored. It writes nothing, and `rdata_o` keeps its value.
- R10: `rdata_o` takes the addressed word at the clock edge that ends a read cycle. It holds that value through every cycle that is not a read of the window.
- R11: Requests are level-sensitive. When a line drops, its output falls one cycle later, with no memory of the earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus cycle valid |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address; bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| src_i | input | 32 | Peripheral request lines, active high |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
A register write and a change on the request lines can land in the same cycle. In that cycle the outputs must be built from the new line values but the old enable and routing bits, and the new register value takes effect only one edge later. The bench provokes this case on purpose: it writes the routing register in the very cycle a line rises, so the request shows up first on `irq_o` and then moves to `fiq_o`. A per-clock model also replays random bus traffic against random line activity, so such overlaps occur many times. The model judges every cycle's outputs and read data.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  // word index inside the register window (byte offset >> 2)
  typedef enum logic [2:0] {
    RI_RAW   = 3'd0,
    RI_EN    = 3'd1,
    RI_ROUTE = 3'd2,
    RI_NPEND = 3'd3,
    RI_FPEND = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int WIN_BITS = 5,
  parameter logic [AW-1:0] BASE_ADDR = 32'h9005_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] npend_i,
  input  logic [N_SRC-1:0] fpend_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] route_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int IDX_W = WIN_BITS - 2;

  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             wr_en, wr_route, rd_hit;
  logic [N_SRC-1:0] en_q, route_q;
  logic [DW-1:0]    rd_word, rdata_q;
  logic             unused_bits;

  assign in_win   = sel_i && (addr_i[AW-1:WIN_BITS] == BASE_ADDR[AW-1:WIN_BITS]);
  assign idx      = addr_i[WIN_BITS-1:2];
  assign wr_en    = in_win && wr_i && (idx == IDX_W'(RI_EN));
  assign wr_route = in_win && wr_i && (idx == IDX_W'(RI_ROUTE));
  assign rd_hit   = in_win && !wr_i;
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
    end else begin
      if (wr_en)    en_q    <= wdata_i[N_SRC-1:0];
      if (wr_route) route_q <= wdata_i[N_SRC-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    case (idx)
      IDX_W'(RI_RAW):   rd_word[N_SRC-1:0] = src_i;
      IDX_W'(RI_EN):    rd_word[N_SRC-1:0] = en_q;
      IDX_W'(RI_ROUTE): rd_word[N_SRC-1:0] = route_q;
      IDX_W'(RI_NPEND): rd_word[N_SRC-1:0] = npend_i;
      IDX_W'(RI_FPEND): rd_word[N_SRC-1:0] = fpend_i;
      default:          rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_word;
  end

  assign en_o    = en_q;
  assign route_o = route_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_steer_lanes.sv
module irq_steer_lanes #(
  parameter int N_SRC = 32
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] route_i,
  output logic [N_SRC-1:0] npend_o,
  output logic [N_SRC-1:0] fpend_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_lane
    logic live;
    assign live       = src_i[g] & en_i[g];
    assign npend_o[g] = live & ~route_i[g];
    assign fpend_o[g] = live &  route_i[g];
  end
endmodule

// File: rtl/irq_steer_out.sv
module irq_steer_out #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] npend_i,
  input  logic [N_SRC-1:0] fpend_i,
  output logic             irq_o,
  output logic             fiq_o
);
  logic irq_q, fiq_q;

  // registered so the processor pins see glitch-free levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |npend_i;
      fiq_q <= |fpend_i;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl #(
  parameter int N_SRC = 32,
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int WIN_BITS = 5,
  parameter logic [AW-1:0] BASE_ADDR = 32'h9005_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_SRC-1:0] src_i,
  output logic             irq_o,
  output logic             fiq_o
);
  logic [N_SRC-1:0] mask_q, level_q, npend, fpend;

  irq_steer_regs #(
    .N_SRC(N_SRC), .DW(DW), .AW(AW), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .src_i(src_i),
    .npend_i(npend), .fpend_i(fpend),
    .en_o(mask_q), .route_o(level_q), .rdata_o(rdata_o)
  );

  irq_steer_lanes #(.N_SRC(N_SRC)) u_lanes (
    .src_i(src_i), .en_i(mask_q), .route_i(level_q),
    .npend_o(npend), .fpend_o(fpend)
  );

  irq_steer_out #(.N_SRC(N_SRC)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .npend_i(npend), .fpend_i(fpend),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int N_SRC = 32,
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int WIN_BITS = 5,
  parameter logic [AW-1:0] BASE_ADDR = 32'h9005_0000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             wr_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [N_SRC-1:0] src_i,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] level_q
);
  logic win, en_wr;
  assign win   = sel_i && (addr_i[AW-1:WIN_BITS] == BASE_ADDR[AW-1:WIN_BITS]);
  assign en_wr = win && wr_i && (addr_i[WIN_BITS-1:2] == (WIN_BITS-2)'(1));

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(src_i & mask_q & ~level_q))); // R5
  AST_FIQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == $past(|(src_i & mask_q & level_q))); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> (!irq_o && !fiq_o)); // R3
  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> (mask_q == $past(wdata_i[N_SRC-1:0]))); // R2
  AST_FOREIGN_NOWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && !win) |=> ($stable(mask_q) && $stable(level_q))); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win && !wr_i) |=> $stable(rdata_o)); // R10
endmodule

bind irq_steer_ctrl irq_steer_chk #(
  .N_SRC(N_SRC), .DW(DW), .AW(AW), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .src_i(src_i), .irq_o(irq_o),
  .fiq_o(fiq_o), .mask_q(mask_q), .level_q(level_q)
);

// File: tb/sim_irq_steer_ctrl.sv
`timescale 1ns/1ps
module sim_irq_steer_ctrl;
  localparam logic [31:0] BASE = 32'h9005_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [31:0] addr = '0, wdata = '0, src = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_steer_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq), .fiq_o(fiq)
  );

  // behavioural reference, advanced at each rising edge
  logic [31:0] m_en, m_route, m_rdata;
  logic        m_irq, m_fiq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_route = 0; m_rdata = 0; m_irq = 0; m_fiq = 0;
    end else begin
      m_irq = (src & m_en & ~m_route) != 0;
      m_fiq = (src & m_en & m_route) != 0;
      if (sel && addr[31:5] == BASE[31:5]) begin
        if (!wr) begin
          case (addr[4:2])
            3'd0: m_rdata = src;
            3'd1: m_rdata = m_en;
            3'd2: m_rdata = m_route;
            3'd3: m_rdata = src & m_en & ~m_route;
            3'd4: m_rdata = src & m_en & m_route;
            default: m_rdata = 0;
          endcase
        end else if (addr[4:2] == 3'd1) m_en = wdata;
        else if (addr[4:2] == 3'd2) m_route = wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (irq !== m_irq) begin fails++; $display("FAIL R5 irq_o got %0b exp %0b", irq, m_irq); end
      if (fiq !== m_fiq) begin fails++; $display("FAIL R6 fiq_o got %0b exp %0b", fiq, m_fiq); end
      if (rdata !== m_rdata) begin fails++; $display("FAIL R10 rdata_o got %h exp %h", rdata, m_rdata); end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [31:0] a, logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [31:0] a, string tag, logic [31:0] exp);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    sel = 0;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq_o in reset", {31'b0, irq}, 0);
    chk("R1 rdata_o in reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq_o", {31'b0, irq}, 0);
    chk("R1 fiq_o", {31'b0, fiq}, 0);
    bus_rd(BASE + 4, "R1 enable", 0);
    bus_rd(BASE + 8, "R1 routing", 0);

    // all lines high, nothing enabled
    src = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R3 masked irq_o", {31'b0, irq}, 0);
    bus_rd(BASE + 12, "R3 masked pend", 0);

    bus_wr(BASE + 4, 32'h3F00_000F);
    bus_wr(BASE + 8, 32'h0C00_0003);
    bus_rd(BASE + 4, "R2 enable", 32'h3F00_000F);
    bus_rd(BASE + 8, "R2 routing", 32'h0C00_0003);

    src = 32'h0100_0001;
    @(negedge clk);
    chk("R5 irq_o", {31'b0, irq}, 1);
    chk("R6 fiq_o", {31'b0, fiq}, 1);
    bus_rd(BASE + 12, "R3 normal pend", 32'h0100_0000);
    bus_rd(BASE + 16, "R4 fast pend", 32'h0000_0001);
    bus_rd(BASE + 0, "R7 raw", 32'h0100_0001);

    src = 32'h0400_0000; // timer line routed fast
    @(negedge clk);
    chk("R11 irq_o drop", {31'b0, irq}, 0);
    chk("R6 fiq_o timer", {31'b0, fiq}, 1);
    src = 0;
    @(negedge clk);
    chk("R11 fiq_o drop", {31'b0, fiq}, 0);

    bus_wr(BASE + 0, 32'h0);
    bus_wr(BASE + 12, 32'h0);
    bus_wr(BASE + 16, 32'h0);
    bus_wr(BASE + 24, 32'h0);
    bus_rd(BASE + 4, "R8 enable kept", 32'h3F00_000F);
    bus_rd(BASE + 8, "R8 routing kept", 32'h0C00_0003);
    bus_rd(BASE + 24, "R8 unmapped read", 0);

    bus_rd(BASE + 4, "R2 enable again", 32'h3F00_000F);
    bus_wr(32'h9006_0004, 32'h0);
    bus_rd(32'h9006_0008, "R9 foreign read", 32'h3F00_000F);
    bus_rd(BASE + 4, "R9 enable kept", 32'h3F00_000F);

    bus_wr(BASE + 4, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    chk("R10 rdata held", rdata, 32'h3F00_000F);

    // collision: line rises in the same cycle routing is rewritten
    bus_wr(BASE + 8, 32'h0);
    sel = 1; wr = 1; addr = BASE + 8; wdata = 32'h1; src = 32'h1;
    @(negedge clk);
    sel = 0; wr = 0;
    chk("R5 collision old routing", {31'b0, irq}, 1);
    chk("R6 collision old routing", {31'b0, fiq}, 0);
    @(negedge clk);
    chk("R5 collision new routing", {31'b0, irq}, 0);
    chk("R6 collision new routing", {31'b0, fiq}, 1);

    for (int i = 0; i < 400; i++) begin
      sel   = ($urandom % 3) != 0;
      wr    = $urandom % 2;
      addr  = (($urandom % 8) == 0) ? 32'h9004_0000 + ($urandom % 64) : BASE + ($urandom % 32);
      wdata = $urandom;
      if (($urandom % 2) == 0) src = $urandom;
      @(negedge clk);
    end
    sel = 0;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule